// File: doc/BRIEF.md
# Timer Host Register Interface

This block is the host-facing side of a three-channel interval timer. A host on an 8-bit data bus with a 2-bit address writes control bytes and count bytes and reads count bytes back. Addresses 0, 1 and 2 are the count data ports of channels 0, 1 and 2. Address 3 takes control bytes. A control byte either reprograms one channel's access mode, count mode and number format, or asks that channel to capture its running count.

Count bytes written to a channel are assembled into a 16-bit initial count. The order and number of bytes follow that channel's access mode. Once the count is complete, the block hands it to the counter logic as a one-cycle load pulse, together with the channel's count mode and BCD flag. On reads, the block returns bytes of the live down-counter value. If a latch command was given, it returns bytes of a frozen snapshot instead, until that snapshot has been fully read. The counters themselves sit outside this block and feed their current values back in.

Top module: `tmr_host_if`

## Requirements
- R1: A control byte carries the channel in bits 7:6. Code 3 in bits 7:6 has no effect on any channel.
- R2: A control byte with count mode bits 3:1 set to 6 or 7 has no effect on any channel.
- R3: Access mode 01 (bits 5:4) is high byte only. One data write loads the count {byte, 8'h00}.
- R4: Access mode 10 is low byte only. One data write loads the count {8'h00, byte}.
- R5: Access mode 11 takes the low byte and then the high byte. The first write produces no load. The second write loads {second, first}.
- R6: A completed count write raises the load strobe of that channel alone, for exactly one cycle, in the cycle after the write. The strobe carries the 16-bit count, the count mode from control bits 3:1, and the BCD flag from control bit 0.
- R7: Writing a valid control byte to a channel resets its write and read byte sequencing so that the low byte comes first.
- R8: Access mode 00 is a latch command. It copies the channel's live count into a snapshot and leaves the stored configuration unchanged. Reads then return snapshot bytes while the live count changes.
- R9: A snapshot is held until it has been fully read in the channel's access mode: one read for the single-byte modes, low then high for mode 11. Latch commands given while a snapshot is held are ignored.
- R10: With no snapshot held, reads return the live count bytes in the configured order. Read data appears on rdata in the cycle after rd_en.
- R11: A read of address 3 returns 8'h00.
- R12: After reset, every channel is in access mode 11, count mode 0, binary, with no snapshot held. The load strobes and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write cycle |
| rd_en | input | 1 | Bus read cycle |
| addr | input | 2 | 0..2 selects a channel data port, 3 selects the control port |
| wdata | input | 8 | Write data |
| live_cnt | input | 48 | Current down-counter value of each channel, channel i at bits 16i+15:16i |
| rdata | output | 8 | Read data, registered |
| ld_stb | output | 3 | One-cycle load pulse per channel |
| ld_count | output | 48 | Assembled initial count per channel |
| ld_mode | output | 9 | Count mode per channel, 3 bits each |
| ld_bcd | output | 3 | BCD flag per channel |

## Verification
A table of control-and-data sequences loads every channel in all three byte access modes, using several count modes and both number formats. Each entry checks that the expected count shows up on only that channel's strobe. This separates byte placement errors from channel decode errors. Directed sequences then send an illegal channel code, an out-of-range mode and a control byte written halfway through a two-byte load. Each is followed by data writes whose strobe timing shows whether the stored state was disturbed. Reads compare live and latched paths by changing the live count between a latch command and the byte reads, and by issuing a second latch that must not overwrite the snapshot.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the timer host interface.
// Assumes an 8-bit data bus and 16-bit counters.
package tmr_pkg;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 16;
    localparam int MODE_W    = 3;
    localparam int ADDR_W    = 2;
    localparam int MAX_MODE  = 5;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_HI    = 2'b01,
        ACC_LO    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{acc: ACC_LOHI, mode: '0, bcd: 1'b0};
endpackage

// File: rtl/tmr_ctl_decode.sv
// Decodes a control byte written to the control address into a
// per-channel configuration write or a per-channel latch request.
// Assumes NCH <= 3, so channel code 3 never matches a channel.
module tmr_ctl_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    cfg_we,
    output logic [NCH-1:0]    latch_req,
    output chan_cfg_t         new_cfg
);
    logic       ctl_sel;
    logic       mode_ok;
    logic [1:0] ch_code;

    // Split the control byte into its fields and screen the mode code.
    always_comb begin
        ctl_sel      = wr_en && (addr == CTRL_ADDR);
        ch_code      = wdata[7:6];
        new_cfg.acc  = acc_e'(wdata[5:4]);
        new_cfg.mode = wdata[3:1];
        new_cfg.bcd  = wdata[0];
        mode_ok      = (int'(wdata[3:1]) <= MAX_MODE);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Route a program or latch command to channel i.
        always_comb begin
            cfg_we[i]    = ctl_sel && (ch_code == 2'(i)) && (new_cfg.acc != ACC_LATCH) && mode_ok;
            latch_req[i] = ctl_sel && (ch_code == 2'(i)) && (new_cfg.acc == ACC_LATCH);
        end
    end

    // R1
    illegal_ch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR && wdata[7:6] == 2'b11) |-> (cfg_we == '0 && latch_req == '0));
    // R2
    bad_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR && wdata[3:1] > 3'd5) |-> (cfg_we == '0));
    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we | latch_req));
endmodule

// File: rtl/tmr_chan_port.sv
// One channel's slice of the host interface: stored configuration,
// write byte assembly with load strobe, read byte sequencing, and the
// count snapshot. Assumes writes and reads to this channel never coincide
// with a control byte (they use different addresses).
module tmr_chan_port
    import tmr_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  chan_cfg_t         new_cfg,
    input  logic              latch_req,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_count,
    output logic [MODE_W-1:0] ld_mode,
    output logic              ld_bcd
);
    chan_cfg_t          cfg;
    logic               wr_hi_next;
    logic               rd_hi_next;
    logic [BYTE_W-1:0]  lo_hold;
    logic               latched;
    logic [CNT_W-1:0]   snap;
    logic [CNT_W-1:0]   src;
    logic               wr_hit;
    logic               rd_hit;

    // Address match and read source selection.
    always_comb begin
        wr_hit = wr_en && (addr == ADDR_W'(CH));
        rd_hit = rd_en && (addr == ADDR_W'(CH));
        src    = latched ? snap : live_cnt;
        case (cfg.acc)
            ACC_HI:  rd_byte = src[CNT_W-1:BYTE_W];
            ACC_LO:  rd_byte = src[BYTE_W-1:0];
            default: rd_byte = rd_hi_next ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        endcase
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= CFG_RESET;
        else if (cfg_we) cfg <= new_cfg;
    end

    // Write byte assembly and one-cycle load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hi_next <= 1'b0;
            lo_hold    <= '0;
            ld_stb     <= 1'b0;
            ld_count   <= '0;
            ld_mode    <= '0;
            ld_bcd     <= 1'b0;
        end else begin
            ld_stb <= 1'b0;
            if (cfg_we) begin
                wr_hi_next <= 1'b0;
            end else if (wr_hit) begin
                ld_mode <= cfg.mode;
                ld_bcd  <= cfg.bcd;
                case (cfg.acc)
                    ACC_HI: begin
                        ld_stb   <= 1'b1;
                        ld_count <= {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_LO: begin
                        ld_stb   <= 1'b1;
                        ld_count <= {{BYTE_W{1'b0}}, wdata};
                    end
                    default: begin
                        if (!wr_hi_next) begin
                            lo_hold    <= wdata;
                            wr_hi_next <= 1'b1;
                        end else begin
                            ld_stb     <= 1'b1;
                            ld_count   <= {wdata, lo_hold};
                            wr_hi_next <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    // Read byte toggle, snapshot capture and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hi_next <= 1'b0;
            latched    <= 1'b0;
            snap       <= '0;
        end else begin
            if (cfg_we)
                rd_hi_next <= 1'b0;
            else if (rd_hit && cfg.acc == ACC_LOHI)
                rd_hi_next <= ~rd_hi_next;
            if (rd_hit && latched && (cfg.acc != ACC_LOHI || rd_hi_next))
                latched <= 1'b0;
            else if (latch_req && !latched) begin
                snap    <= live_cnt;
                latched <= 1'b1;
            end
        end
    end

    // R6
    stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |-> ($past(wr_en) && $past(addr) == ADDR_W'(CH)));
    // R3
    hi_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && $past(cfg.acc) == ACC_HI) |-> (ld_count[BYTE_W-1:0] == '0));
    // R4
    lo_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && $past(cfg.acc) == ACC_LO) |-> (ld_count[CNT_W-1:BYTE_W] == '0));
    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !rd_hit) |=> (latched && $stable(snap)));
    // R7
    wr_toggle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_next |-> (cfg.acc == ACC_LOHI));
endmodule

// File: rtl/tmr_host_if.sv
// Host register interface of a multi-channel timer: control byte decode,
// per-channel count assembly and load strobes, and registered byte reads
// of live or latched counts. Assumes NCH <= 3 (2-bit address, 3 = control).
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BYTE_W-1:0]      wdata,
    input  logic [NCH*CNT_W-1:0]   live_cnt,
    output logic [BYTE_W-1:0]      rdata,
    output logic [NCH-1:0]         ld_stb,
    output logic [NCH*CNT_W-1:0]   ld_count,
    output logic [NCH*MODE_W-1:0]  ld_mode,
    output logic [NCH-1:0]         ld_bcd
);
    logic [NCH-1:0]    cfg_we;
    logic [NCH-1:0]    latch_req;
    chan_cfg_t         new_cfg;
    logic [BYTE_W-1:0] rd_byte [NCH];
    logic [BYTE_W-1:0] sel_byte;

    tmr_ctl_decode #(.NCH(NCH)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cfg_we    (cfg_we),
        .latch_req (latch_req),
        .new_cfg   (new_cfg)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tmr_chan_port #(.CH(i)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we[i]),
            .new_cfg   (new_cfg),
            .latch_req (latch_req[i]),
            .wr_en     (wr_en),
            .rd_en     (rd_en),
            .addr      (addr),
            .wdata     (wdata),
            .live_cnt  (live_cnt[i*CNT_W +: CNT_W]),
            .rd_byte   (rd_byte[i]),
            .ld_stb    (ld_stb[i]),
            .ld_count  (ld_count[i*CNT_W +: CNT_W]),
            .ld_mode   (ld_mode[i*MODE_W +: MODE_W]),
            .ld_bcd    (ld_bcd[i])
        );
    end

    // Pick the addressed channel's byte; the control address reads as zero.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == ADDR_W'(i)) sel_byte = rd_byte[i];
    end

    // Register read data for the cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel_byte;
    end

    // R11
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(addr) == CTRL_ADDR) |-> (rdata == '0));
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));
endmodule

// File: tb/tb_tmr_host_if.sv
module tb_tmr_host_if;
    localparam int NCH = 3;
    localparam int NV  = 7;
    // Vector: {control byte, first data byte, second data byte, expected count}
    localparam logic [39:0] VEC [NV] = '{
        {8'h36, 8'h00, 8'h00, 16'h0000},
        {8'h54, 8'h12, 8'h00, 16'h1200},
        {8'hB6, 8'h33, 8'h05, 16'h0533},
        {8'h65, 8'h99, 8'h00, 16'h0099},
        {8'h9A, 8'hAB, 8'h00, 16'hAB00},
        {8'h28, 8'h7F, 8'h00, 16'h007F},
        {8'h33, 8'h34, 8'h12, 16'h1234}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                  rst_n = 1'b0;
    logic                  wr_en = 1'b0;
    logic                  rd_en = 1'b0;
    logic [1:0]            addr  = '0;
    logic [7:0]            wdata = '0;
    logic [NCH*16-1:0]     live_cnt = '0;
    logic [7:0]            rdata;
    logic [NCH-1:0]        ld_stb;
    logic [NCH*16-1:0]     ld_count;
    logic [NCH*3-1:0]      ld_mode;
    logic [NCH-1:0]        ld_bcd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    tmr_host_if #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .live_cnt(live_cnt), .rdata(rdata), .ld_stb(ld_stb),
        .ld_count(ld_count), .ld_mode(ld_mode), .ld_bcd(ld_bcd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic chk_load(input string req, input int ch, input logic [15:0] cnt,
                            input logic [2:0] mode, input logic bcd);
        chk({req, " strobe"}, 32'(ld_stb), 32'(1 << ch));
        chk({req, " count"}, 32'(ld_count[ch*16 +: 16]), 32'(cnt));
        chk({req, " mode"}, 32'(ld_mode[ch*3 +: 3]), 32'(mode));
        chk({req, " bcd"}, 32'(ld_bcd[ch]), 32'(bcd));
        @(negedge clk);
        chk("R6 strobe one cycle", 32'(ld_stb), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 rdata", 32'(rdata), 32'h0);
        chk("R12 strobe", 32'(ld_stb), 32'h0);
        wr(2'd1, 8'h11);
        chk("R12 lohi first byte no load", 32'(ld_stb), 32'h0);
        wr(2'd1, 8'h22);
        chk_load("R12 reset config", 1, 16'h2211, 3'd0, 1'b0);

        // Table of loads: R3 high only, R4 low only, R5 low then high
        for (int i = 0; i < NV; i++) begin
            logic [7:0] c;
            int ch;
            c  = VEC[i][39:32];
            ch = int'(c[7:6]);
            wr(2'd3, c);
            if (c[5:4] == 2'b11) begin
                wr(2'(ch), VEC[i][31:24]);
                chk("R5 no load after low byte", 32'(ld_stb), 32'h0);
                wr(2'(ch), VEC[i][23:16]);
                chk_load("R5 two-byte load", ch, VEC[i][15:0], c[3:1], c[0]);
            end else begin
                wr(2'(ch), VEC[i][31:24]);
                chk_load(c[5:4] == 2'b01 ? "R3 high-only load" : "R4 low-only load",
                         ch, VEC[i][15:0], c[3:1], c[0]);
            end
        end

        // R1 illegal channel code: ch0 stays in two-byte mode 1 BCD
        wr(2'd3, 8'hD2);
        wr(2'd0, 8'h55);
        chk("R1 illegal channel ignored", 32'(ld_stb), 32'h0);
        wr(2'd0, 8'h66);
        chk_load("R1 config kept", 0, 16'h6655, 3'd1, 1'b1);

        // R2 out-of-range mode ignored
        wr(2'd3, 8'h1C);
        wr(2'd0, 8'h01);
        chk("R2 bad mode ignored", 32'(ld_stb), 32'h0);
        wr(2'd0, 8'h02);
        chk_load("R2 config kept", 0, 16'h0201, 3'd1, 1'b1);

        // R7 control byte mid-sequence restarts at the low byte
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'h44);
        wr(2'd3, 8'hB4);
        wr(2'd2, 8'h10);
        chk("R7 toggle reset", 32'(ld_stb), 32'h0);
        wr(2'd2, 8'h20);
        chk_load("R7 restarted load", 2, 16'h2010, 3'd2, 1'b0);

        // R10 live reads in configured order
        live_cnt[2*16 +: 16] = 16'hBEEF;
        rd(2'd2, v); chk("R10 live low byte", 32'(v), 32'hEF);
        rd(2'd2, v); chk("R10 live high byte", 32'(v), 32'hBE);
        live_cnt[1*16 +: 16] = 16'h1357;
        rd(2'd1, v); chk("R10 low-only live", 32'(v), 32'h57);
        rd(2'd1, v); chk("R10 low-only live again", 32'(v), 32'h57);

        // R8 and R9 latch on two-byte channel
        live_cnt[2*16 +: 16] = 16'h1234;
        wr(2'd3, 8'h80);
        live_cnt[2*16 +: 16] = 16'h5678;
        wr(2'd3, 8'h80);
        rd(2'd2, v); chk("R8 latched low byte", 32'(v), 32'h34);
        live_cnt[2*16 +: 16] = 16'h9999;
        rd(2'd2, v); chk("R9 second latch ignored", 32'(v), 32'h12);
        live_cnt[2*16 +: 16] = 16'hA1B2;
        rd(2'd2, v); chk("R9 released after full read low", 32'(v), 32'hB2);
        rd(2'd2, v); chk("R9 released after full read high", 32'(v), 32'hA1);

        // R9 single-byte channel releases after one read
        live_cnt[1*16 +: 16] = 16'hAA55;
        wr(2'd3, 8'h40);
        live_cnt[1*16 +: 16] = 16'h0000;
        rd(2'd1, v); chk("R8 low-only latched", 32'(v), 32'h55);
        rd(2'd1, v); chk("R9 low-only released", 32'(v), 32'h00);

        // R11 control address reads zero
        live_cnt = '1;
        rd(2'd3, v); chk("R11 control read", 32'(v), 32'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule